// File: doc/BRIEF.md
# Rectified-Sine Reference Generator

This block supplies the two modulating references of a two-module, single-carrier multilevel PWM modulator. An internal step counter walks a sine table of one half cycle. Each table value is multiplied by an 8-bit amplitude word, which sets the modulation index. The product is the reference for the lower module. The upper-module reference is the same value shifted up by a fixed offset of one voltage level. A carrier generator and comparators elsewhere consume both references.

A full cycle of the fundamental is 244 steps. The table has 122 entries and is replayed on every half cycle. A polarity flag tells the two half cycles apart. All outputs are registered. They move only on cycles where the step enable is high, so the caller sets the sampling rate through that enable. For example, one step of about 81.96 µs at a 50 Hz fundamental gives about 1.48 degrees of switching-instant resolution.

Top module: `rsine_ref_gen`

## Requirements
- R1: A synchronous reset sets step_idx_o to 0, half_o to 0, ref_lo_o to 0 and ref_hi_o to 0 at the next clock edge.
- R2: On a clock edge where step_en_i is low and reset is low, no output changes.
- R3: Each enabled step presents the next table sample. The first enabled step after reset presents sample 0. The index then counts 1, 2 … 121 and returns to 0. step_idx_o always gives the index of the sample currently shown on the references.
- R4: Table entry u equals round(85 × sin((180/488 + 360/488·u) degrees)) for u = 0 … 121. The entries rise from 1 at u = 0 to 85 at u = 121.
- R5: On an enabled step, ref_lo_o becomes table[index] × amp_i. The value of amp_i is taken in that same cycle and placed zero-extended in 16 bits.
- R6: On an enabled step, ref_hi_o becomes ref_lo_o + OFFSET modulo 2^16. The default OFFSET is 85 × 255 = 21675.
- R7: half_o is 0 for samples of the first pass through the table after reset. It inverts for each later pass, changing together with the sample whose index returns to 0.
- R8: An amplitude of 0 gives ref_lo_o = 0 and ref_hi_o = OFFSET. An amplitude of 255 gives the full product without overflow, for example 85 × 255 = 21675 at u = 121.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| step_en_i | input | 1 | Advance to the next sample on this cycle |
| amp_i | input | 8 | Amplitude word (modulation index) |
| ref_lo_o | output | 16 | Lower-module reference |
| ref_hi_o | output | 16 | Upper-module reference (lower plus offset) |
| half_o | output | 1 | Half-cycle polarity flag |
| step_idx_o | output | 7 | Table index of the sample being shown |

## Verification
Each result is due exactly one clock edge after its stimulus. An enabled cycle updates all four outputs at its rising edge, and an asserted reset clears them at its rising edge. There is no extra pipeline stage between the table, the multiplier and the output register. The bench therefore drives step_en_i and amp_i at the falling edge, lets one rising edge pass, and compares at the next falling edge. It recomputes the sine entry, product and offset sum from the requirement formulas and tracks the expected index and polarity on its own. Hold behaviour is checked by leaving the enable low for several edges and confirming that every output still has its earlier value.

// File: rtl/rsine_pkg.sv
package rsine_pkg;

    localparam real RSINE_PI = 3.14159265358979323846;

    // Rounded half-cycle table entry u; the phase is centred in each step
    function automatic int sine_entry(input int u, input int steps_full, input int scale);
        real deg;
        real val;
        deg = (180.0 / (2.0 * steps_full)) + (360.0 / (2.0 * steps_full)) * u;
        val = scale * $sin(deg * RSINE_PI / 180.0);
        return $rtoi(val + 0.5);
    endfunction

endpackage

// File: rtl/rsine_step_ctr.sv
module rsine_step_ctr #(
    parameter int STEPS_HALF = 122,
    localparam int IDX_W = $clog2(STEPS_HALF)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    output logic [IDX_W-1:0] cnt_o,
    output logic             pol_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(STEPS_HALF - 1);

    typedef struct packed {
        logic [IDX_W-1:0] cnt;
        logic             pol;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                st_d.pol = ~st_q.pol;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign pol_o = st_q.pol;
endmodule

// File: rtl/rsine_table.sv
module rsine_table #(
    parameter int STEPS_HALF = 122,
    parameter int FULL_SCALE = 85,
    localparam int IDX_W = $clog2(STEPS_HALF),
    localparam int TBL_W = $clog2(FULL_SCALE + 1)
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [TBL_W-1:0] val_o
);
    logic [TBL_W-1:0] rom [STEPS_HALF];

    for (genvar g = 0; g < STEPS_HALF; g++) begin : g_entry
        localparam int ENTRY = rsine_pkg::sine_entry(g, 2 * STEPS_HALF, FULL_SCALE);
        assign rom[g] = TBL_W'(ENTRY);
    end

    always_comb begin
        val_o = '0;
        if (int'(idx_i) < STEPS_HALF) val_o = rom[idx_i];
    end
endmodule

// File: rtl/rsine_scale.sv
module rsine_scale #(
    parameter int TBL_W  = 7,
    parameter int AMP_W  = 8,
    parameter int REF_W  = 16,
    parameter int OFFSET = 21675
) (
    input  logic [TBL_W-1:0] tbl_i,
    input  logic [AMP_W-1:0] amp_i,
    output logic [REF_W-1:0] lo_o,
    output logic [REF_W-1:0] hi_o
);
    localparam int PROD_W = TBL_W + AMP_W;

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod = PROD_W'(tbl_i) * PROD_W'(amp_i);
        lo_o = REF_W'(prod);
        hi_o = lo_o + REF_W'(OFFSET);
    end
endmodule

// File: rtl/rsine_ref_gen.sv
module rsine_ref_gen #(
    parameter int STEPS_HALF = 122,
    parameter int FULL_SCALE = 85,
    parameter int AMP_W      = 8,
    parameter int REF_W      = 16,
    parameter int OFFSET     = 85 * 255,
    localparam int IDX_W = $clog2(STEPS_HALF),
    localparam int TBL_W = $clog2(FULL_SCALE + 1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             step_en_i,
    input  logic [AMP_W-1:0] amp_i,
    output logic [REF_W-1:0] ref_lo_o,
    output logic [REF_W-1:0] ref_hi_o,
    output logic             half_o,
    output logic [IDX_W-1:0] step_idx_o
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             pol;
        logic [REF_W-1:0] lo;
        logic [REF_W-1:0] hi;
    } out_t;

    logic [IDX_W-1:0] cnt;
    logic             pol;
    logic [TBL_W-1:0] tbl;
    logic [REF_W-1:0] lo_c, hi_c;
    out_t             out_d, out_q;

    rsine_step_ctr #(.STEPS_HALF(STEPS_HALF)) ctr_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .en_i  (step_en_i),
        .cnt_o (cnt),
        .pol_o (pol)
    );

    rsine_table #(.STEPS_HALF(STEPS_HALF), .FULL_SCALE(FULL_SCALE)) tbl_i (
        .idx_i (cnt),
        .val_o (tbl)
    );

    rsine_scale #(.TBL_W(TBL_W), .AMP_W(AMP_W), .REF_W(REF_W), .OFFSET(OFFSET)) scl_i (
        .tbl_i (tbl),
        .amp_i (amp_i),
        .lo_o  (lo_c),
        .hi_o  (hi_c)
    );

    always_comb begin
        out_d = out_q;
        if (step_en_i) begin
            out_d.idx = cnt;
            out_d.pol = pol;
            out_d.lo  = lo_c;
            out_d.hi  = hi_c;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) out_q <= '0;
        else       out_q <= out_d;
    end

    assign ref_lo_o   = out_q.lo;
    assign ref_hi_o   = out_q.hi;
    assign half_o     = out_q.pol;
    assign step_idx_o = out_q.idx;
endmodule

// File: rtl/rsine_ref_chk.sv
module rsine_ref_chk #(
    parameter int STEPS_HALF = 122,
    parameter int REF_W      = 16,
    parameter int OFFSET     = 85 * 255,
    localparam int IDX_W = $clog2(STEPS_HALF)
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             step_en_i,
    input logic [REF_W-1:0] ref_lo_o,
    input logic [REF_W-1:0] ref_hi_o,
    input logic             half_o,
    input logic [IDX_W-1:0] step_idx_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(STEPS_HALF - 1);

    logic seen_q;
    always_ff @(posedge clk_i) begin
        if (rst_i)          seen_q <= 1'b0;
        else if (step_en_i) seen_q <= 1'b1;
    end

    a_r1_reset_clears: assert property (@(posedge clk_i)
        rst_i |=> (step_idx_o == '0 && !half_o && ref_lo_o == '0 && ref_hi_o == '0));

    a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        !step_en_i |=> ($stable(step_idx_o) && $stable(half_o) && $stable(ref_lo_o) && $stable(ref_hi_o)));

    a_r3_index_next: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_en_i && seen_q && step_idx_o != LAST) |=> step_idx_o == $past(step_idx_o) + 1'b1);

    a_r3_index_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_en_i && step_idx_o == LAST) |=> step_idx_o == '0);

    a_r3_index_range: assert property (@(posedge clk_i) disable iff (rst_i)
        step_idx_o <= LAST);

    a_r6_offset_pair: assert property (@(posedge clk_i) disable iff (rst_i)
        seen_q |-> ref_hi_o == ref_lo_o + REF_W'(OFFSET));

    a_r7_pol_flip: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_en_i && step_idx_o == LAST) |=> half_o != $past(half_o));

    a_r7_pol_keep: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_en_i && seen_q && step_idx_o != LAST) |=> $stable(half_o));
endmodule

bind rsine_ref_gen rsine_ref_chk #(
    .STEPS_HALF (STEPS_HALF),
    .REF_W      (REF_W),
    .OFFSET     (OFFSET)
) chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .step_en_i  (step_en_i),
    .ref_lo_o   (ref_lo_o),
    .ref_hi_o   (ref_hi_o),
    .half_o     (half_o),
    .step_idx_o (step_idx_o)
);

// File: tb/rsine_ref_gen_tb.sv
module rsine_ref_gen_tb_top;
    localparam int N    = 122;
    localparam int OFS  = 21675;
    localparam real PI_R = 3.14159265358979323846;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [7:0]  amp = 8'd0;
    logic [15:0] lo, hi;
    logic        half;
    logic [6:0]  idx;

    int checks = 0;
    int errors = 0;
    int exp_idx = 0;
    int exp_pol = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rsine_ref_gen dut_i (
        .clk_i(clk), .rst_i(rst), .step_en_i(en), .amp_i(amp),
        .ref_lo_o(lo), .ref_hi_o(hi), .half_o(half), .step_idx_o(idx)
    );

    function automatic int ref_tbl(input int u);
        real d;
        d = 180.0 / 488.0 + 360.0 / 488.0 * u;
        return $rtoi(85.0 * $sin(d * PI_R / 180.0) + 0.5);
    endfunction

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; en = 1'b0;
        @(negedge clk); rst = 1'b0;
        exp_idx = 0; exp_pol = 0;
    endtask

    // one enabled step; result due at the next falling edge
    task automatic step(input logic [7:0] a);
        int e_lo;
        @(negedge clk); en = 1'b1; amp = a;
        @(negedge clk); en = 1'b0;
        e_lo = ref_tbl(exp_idx) * a;
        chk("R3 idx", idx, exp_idx);
        chk("R7 half", half, exp_pol);
        chk("R5 lo", lo, e_lo);
        chk("R6 hi", hi, (e_lo + OFS) % 65536);
        if (exp_idx == N - 1) begin exp_idx = 0; exp_pol ^= 1; end
        else exp_idx++;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 idx", idx, 0);
        chk("R1 half", half, 0);
        chk("R1 lo", lo, 0);
        chk("R1 hi", hi, 0);
    endtask

    task automatic t_table();
        chk("R4 first", ref_tbl(0), 1);
        chk("R4 last", ref_tbl(N - 1), 85);
        do_reset();
        for (int u = 0; u < N; u++) begin
            step(8'd1);
            chk("R4 entry", lo, ref_tbl(u));
        end
    endtask

    task automatic t_hold();
        logic [15:0] l0, h0; logic p0; logic [6:0] i0;
        step(8'd200);
        l0 = lo; h0 = hi; p0 = half; i0 = idx;
        @(negedge clk); amp = 8'd7;
        repeat (5) @(negedge clk);
        chk("R2 lo", lo, l0);
        chk("R2 hi", hi, h0);
        chk("R2 half", half, p0);
        chk("R2 idx", idx, i0);
    endtask

    task automatic t_two_cycles();
        do_reset();
        for (int k = 0; k < 2 * N + 5; k++) step(8'((k * 37 + 11) % 256));
    endtask

    task automatic t_amp_ends();
        step(8'd0);
        chk("R8 zero lo", lo, 0);
        chk("R8 zero hi", hi, OFS);
        do_reset();
        for (int k = 0; k < N; k++) step(8'd255);
        chk("R8 max lo", lo, 85 * 255);
        chk("R8 max hi", hi, (85 * 255 + OFS) % 65536);
    endtask

    task automatic t_reset_mid();
        for (int k = 0; k < 30; k++) step(8'd90);
        t_reset();
        step(8'd90);
        chk("R3 restart", idx, 0);
    endtask

    initial begin
        t_reset();
        t_table();
        t_hold();
        t_two_cycles();
        t_amp_ends();
        t_reset_mid();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule